// File: doc/BRIEF.md
# Serial Presence Detect Byte Reader

This engine fetches one byte from the configuration EEPROM on a memory module over a two-wire open-drain bus. Software writes a single packed command word that names the device class, the slot, the byte address and the bus speed. The engine then runs the whole read transaction on the wire: it sends the device address, sends the byte address, issues a repeated start, reads the data byte and ends with a stop.

Software polls one 16-bit status word. A busy flag stays set for the whole transaction. When busy clears, the read-valid flag, the error flag and the data byte give the result. Two memory channels with four slots each share the 3-bit slot field: the slot code is the channel number times four plus the slot number.

Top module: `spd_rd_engine`

## Requirements
- R1: After reset the status word reads 0 and neither bus line is pulled low.
- R2: The command word holds the device class in bits 31:28, a fast-clock flag in bit 27, the slot in bits 26:24, the byte address in bits 23:16 and write data in bits 15:8. Bit 0 is the operation, and 0 means read. A read command written while idle sets busy (status bit 12) in the next cycle and clears the result flags and the data byte.
- R3: The 7-bit bus address is the 4-bit device class followed by the 3-bit slot. Only a target answering to that address returns data. A successful read places the addressed byte in status bits 7:0.
- R4: The wire sequence is start, address with write, byte address, repeated start, address with read, one data byte, NACK from the engine, and stop. The engine releases both lines after the stop, at the point where busy clears.
- R5: A missing acknowledge after either address byte sets the error flag (status bit 13). It leaves read-valid at 0 and the data byte at 0, and it ends the transaction with one stop after a single start.
- R6: A missing acknowledge after the byte address has the same result as R5.
- R7: A command written while busy is ignored. The running read completes with its own result, and no second transaction follows.
- R8: A command with bit 0 set is ignored. Busy stays at 0 and the status word is unchanged.
- R9: A full read holds busy for exactly 156 quarter-bit periods. A quarter-bit period is QTR_SLOW cycles when the fast-clock flag is 0 and QTR_FAST cycles when it is 1.
- R10: Read-valid (status bit 15) and error are never set together. When busy clears, exactly one of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_i | input | 32 | Command word |
| status_o | output | 16 | Status word: read-valid, error, busy and data |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | Pull the clock line low when 1 |
| sda_oe_o | output | 1 | Pull the data line low when 1 |

## Verification
The bench attaches a behavioural EEPROM target that acknowledges only the device class 0xA and a set of populated slots. It refuses byte address 0xFF, so missing acknowledges can be forced at the address phase and at the byte-address phase. A design that kept running after a refused acknowledge would report read-valid or a wrong byte, and one that skipped the stop would leave the target out of step for the next read. A command is also written in the middle of a read. A design that accepted it would either corrupt the running address or produce an extra completion that the scoreboard has no entry for. The busy time is measured at both bus speeds, so a divider that is off by one cycle per quarter shows up as a count that misses 156 quarters.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int CMD_DEV_LSB  = 28;
  localparam int CMD_FAST_BIT = 27;
  localparam int CMD_SLOT_LSB = 24;
  localparam int CMD_ADDR_LSB = 16;
  localparam int CMD_OP_BIT   = 0;

  localparam int STS_RDV_BIT  = 15;
  localparam int STS_ERR_BIT  = 13;
  localparam int STS_BUSY_BIT = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_TX, ST_RX, ST_STOP
  } seq_st_e;

  typedef struct packed {
    logic [3:0] dev;
    logic       fast;
    logic [2:0] slot;
    logic [7:0] addr;
  } spd_req_t;
endpackage

// File: rtl/spd_qtick.sv
module spd_qtick #(
  parameter int SLOW = 8,
  parameter int FAST = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int MAXD = (SLOW > FAST) ? SLOW : FAST;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fast_i ? CW'(FAST - 1) : CW'(SLOW - 1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R9: divider never runs past its selected period
  a_r9_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= lim));
endmodule

// File: rtl/spd_bus_seq.sv
module spd_bus_seq
  import spd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  spd_req_t   req_i,
  input  logic       tick_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       ok_o,
  output logic [7:0] data_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  seq_st_e     st_q;
  logic [1:0]  qtr_q;
  logic [3:0]  bit_q;
  logic [1:0]  byte_q;
  logic [7:0]  sh_q;
  logic        nack_q;
  logic        ok_q;
  logic [7:0]  tx_byte;
  logic [2:0]  bsel;
  logic        tx_bit;
  logic        ack_slot;

  always_comb begin
    case (byte_q)
      2'd0:    tx_byte = {req_i.dev, req_i.slot, 1'b0};
      2'd1:    tx_byte = req_i.addr;
      default: tx_byte = {req_i.dev, req_i.slot, 1'b1};
    endcase
  end

  assign bsel     = 3'd7 - bit_q[2:0];
  assign tx_bit   = tx_byte[bsel];
  assign ack_slot = (bit_q == 4'd8);

  // line decode per quarter: clock low in quarters 0 and 3 of a bit
  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (st_q)
      ST_START: begin
        scl_oe_o = ((qtr_q == 2'd0) && (byte_q != 2'd0)) || (qtr_q == 2'd3);
        sda_oe_o = qtr_q[1];
      end
      ST_TX: begin
        scl_oe_o = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_oe_o = !ack_slot && !tx_bit;
      end
      ST_RX: begin
        scl_oe_o = (qtr_q == 2'd0) || (qtr_q == 2'd3);
      end
      ST_STOP: begin
        scl_oe_o = (qtr_q == 2'd0);
        sda_oe_o = !qtr_q[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      qtr_q  <= '0;
      bit_q  <= '0;
      byte_q <= '0;
      sh_q   <= '0;
      nack_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_q   <= ST_START;
        qtr_q  <= '0;
        bit_q  <= '0;
        byte_q <= '0;
        nack_q <= 1'b0;
        ok_q   <= 1'b0;
      end
    end else if (tick_i) begin
      qtr_q <= qtr_q + 1'b1;
      case (st_q)
        ST_START: if (qtr_q == 2'd3) begin
          st_q  <= ST_TX;
          bit_q <= '0;
        end
        ST_TX: begin
          if (qtr_q == 2'd2 && ack_slot) nack_q <= sda_i;
          if (qtr_q == 2'd3) begin
            if (!ack_slot) bit_q <= bit_q + 1'b1;
            else begin
              bit_q <= '0;
              if (nack_q) begin
                st_q <= ST_STOP;
                ok_q <= 1'b0;
              end else begin
                byte_q <= byte_q + 1'b1;
                if (byte_q == 2'd1)      st_q <= ST_START;
                else if (byte_q == 2'd2) st_q <= ST_RX;
              end
            end
          end
        end
        ST_RX: begin
          if (qtr_q == 2'd2 && !ack_slot) sh_q <= {sh_q[6:0], sda_i};
          if (qtr_q == 2'd3) begin
            if (!ack_slot) bit_q <= bit_q + 1'b1;
            else begin
              st_q <= ST_STOP;
              ok_q <= 1'b1;
            end
          end
        end
        ST_STOP: if (qtr_q == 2'd3) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_STOP) && (qtr_q == 2'd3) && tick_i;
  assign ok_o   = ok_q;
  assign data_o = sh_q;

  // R4: data line holds steady while the clock stays released inside a bit
  a_r4_sda_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_TX || st_q == ST_RX) && $past(st_q) == st_q &&
     !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o));

  // R4: a transaction always begins in the start phase
  a_r4_start_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (st_q == ST_START));
endmodule

// File: rtl/spd_rd_engine.sv
module spd_rd_engine
  import spd_pkg::*;
#(
  parameter int QTR_SLOW = 8,
  parameter int QTR_FAST = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_i,
  output logic [15:0] status_o,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o
);
  spd_req_t   req_q;
  logic       rdv_q, err_q;
  logic [7:0] data_q;
  logic       busy, done, ok, tick, accept;
  logic [7:0] rx_data;
  logic       unused_cmd;

  assign unused_cmd = ^cmd_i[15:1];
  assign accept     = cmd_we_i && !busy && !cmd_i[CMD_OP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      rdv_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      req_q.dev  <= cmd_i[CMD_DEV_LSB +: 4];
      req_q.fast <= cmd_i[CMD_FAST_BIT];
      req_q.slot <= cmd_i[CMD_SLOT_LSB +: 3];
      req_q.addr <= cmd_i[CMD_ADDR_LSB +: 8];
      rdv_q      <= 1'b0;
      err_q      <= 1'b0;
      data_q     <= '0;
    end else if (done) begin
      rdv_q  <= ok;
      err_q  <= !ok;
      data_q <= ok ? rx_data : 8'h00;
    end
  end

  spd_qtick #(.SLOW(QTR_SLOW), .FAST(QTR_FAST)) u_qtick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .fast_i (req_q.fast),
    .tick_o (tick)
  );

  spd_bus_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .req_i    (req_q),
    .tick_i   (tick),
    .sda_i    (sda_i),
    .busy_o   (busy),
    .done_o   (done),
    .ok_o     (ok),
    .data_o   (rx_data),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
  );

  always_comb begin
    status_o               = '0;
    status_o[STS_RDV_BIT]  = rdv_q;
    status_o[STS_ERR_BIT]  = err_q;
    status_o[STS_BUSY_BIT] = busy;
    status_o[7:0]          = data_q;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> status_o[STS_BUSY_BIT]);

  a_r7_req_held_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_we_i) |=> $stable(req_q));

  a_r8_write_op_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy && cmd_i[CMD_OP_BIT]) |=> !status_o[STS_BUSY_BIT]);

  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[STS_RDV_BIT] && status_o[STS_ERR_BIT]));

  a_r10_one_flag_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[STS_BUSY_BIT]) |-> (status_o[STS_RDV_BIT] ^ status_o[STS_ERR_BIT]));

  a_r5_err_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STS_ERR_BIT] |-> (status_o[7:0] == 8'h00));
endmodule

// File: tb/sim_spd_rd_engine.sv
`timescale 1ns/1ps
module sim_spd_rd_engine;
  localparam int QS = 8;
  localparam int QF = 2;
  localparam int QTRS_FULL = 156;
  localparam logic [7:0] PRESENT = 8'b0010_0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd = '0;
  logic [15:0] status;
  logic        scl_oe, sda_oe;
  logic        slave_pull = 1'b0;
  wire         scl_w = ~scl_oe;
  wire         sda_w = ~(sda_oe | slave_pull);

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spd_rd_engine #(.QTR_SLOW(QS), .QTR_FAST(QF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .status_o(status), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] mem_byte(input logic [2:0] s, input logic [7:0] a);
    return a ^ {s, 5'b0} ^ 8'h3C;
  endfunction

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // target model on the open-drain lines
  int n_start = 0, n_stop = 0;
  int sstate = 0, scnt = 0;
  logic [7:0] ssh = '0, sbyte = '0, sdat = '0;
  logic [2:0] sslot = '0;
  logic srd = 1'b0;
  logic pscl = 1'b1, psda = 1'b1;
  always begin
    @(scl_w or sda_w);
    if (rst_n) begin
      if (scl_w && pscl && !sda_w && psda) begin
        n_start++; sstate = 1; scnt = 0; slave_pull = 1'b0;
      end else if (scl_w && pscl && sda_w && !psda) begin
        n_stop++; sstate = 0; slave_pull = 1'b0;
      end else if (scl_w && !pscl && sstate != 0) begin
        if (sstate != 3 && scnt < 8) ssh = {ssh[6:0], sda_w};
        scnt++;
      end else if (!scl_w && pscl) begin
        if (sstate == 1 || sstate == 2) begin
          if (scnt == 8) begin
            if (sstate == 1 && ssh[7:4] == 4'hA && PRESENT[ssh[3:1]]) begin
              slave_pull = 1'b1; sslot = ssh[3:1]; srd = ssh[0];
            end else if (sstate == 2 && ssh != 8'hFF) begin
              slave_pull = 1'b1; sbyte = ssh;
            end else sstate = 0;
          end else if (scnt == 9) begin
            slave_pull = 1'b0; scnt = 0;
            if (sstate == 1 && srd) begin
              sstate = 3; sdat = mem_byte(sslot, sbyte); slave_pull = ~sdat[7];
            end else if (sstate == 1) sstate = 2;
            else sstate = 0;
          end
        end else if (sstate == 3) begin
          if (scnt < 8) slave_pull = ~sdat[7 - scnt];
          else if (scnt == 8) slave_pull = 1'b0;
          else begin sstate = 0; slave_pull = 1'b0; end
        end
      end
    end
    pscl = scl_w;
    psda = sda_w;
  end

  typedef struct {
    logic [15:0] st;
    int          dur;
    int          starts;
    string       req;
  } exp_t;
  exp_t sbq[$];

  // monitor: compares each completion against the scoreboard head
  bit prev_busy = 1'b0;
  int busy_cnt = 0, start_base = 0, stop_base = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (status[12]) begin
        if (!prev_busy) begin
          busy_cnt = 1; start_base = n_start; stop_base = n_stop;
        end else busy_cnt++;
      end else if (prev_busy) begin
        if (sbq.size() == 0) chk(1'b0, "R7 unexpected completion", status, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(status == e.st, {e.req, " status"}, status, e.st);
          chk(!scl_oe && !sda_oe, "R4 bus released", {scl_oe, sda_oe}, 0);
          chk(n_stop - stop_base == 1, "R4 R5 one stop", n_stop - stop_base, 1);
          chk(n_start - start_base == e.starts, {e.req, " starts"}, n_start - start_base, e.starts);
          if (e.dur != 0) chk(busy_cnt == e.dur, "R9 busy length", busy_cnt, e.dur);
        end
      end
      prev_busy = status[12];
    end
  end

  task automatic issue(input logic [3:0] dev, input bit fast, input logic [2:0] slot,
                       input logic [7:0] addr, input logic [15:0] exp_st,
                       input int dur, input int starts, input string req);
    exp_t e;
    while (status[12]) @(negedge clk);
    e.st = exp_st; e.dur = dur; e.starts = starts; e.req = req;
    sbq.push_back(e);
    cmd    = {dev, fast, slot, addr, 8'hA5, 7'h00, 1'b0};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(status[12] == 1'b1, "R2 busy set", status[12], 1);
    chk(status[15] == 1'b0 && status[13] == 1'b0 && status[7:0] == 0, "R2 result cleared", status, 16'h1000);
  endtask

  task automatic wait_done();
    while (sbq.size() != 0 || status[12]) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] ok_st(input logic [2:0] s, input logic [7:0] a);
    return 16'h8000 | {8'h00, mem_byte(s, a)};
  endfunction

  initial begin
    logic [15:0] held;
    repeat (5) @(negedge clk);
    chk(status == 16'h0000, "R1 status at reset", status, 0);
    chk(!scl_oe && !sda_oe, "R1 bus idle at reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 16'h0000, "R1 status after reset", status, 0);

    issue(4'hA, 1'b0, 3'd0, 8'h10, ok_st(3'd0, 8'h10), QTRS_FULL * QS, 2, "R3 R4 R10 read slot0");
    issue(4'hA, 1'b1, 3'd5, 8'h80, ok_st(3'd5, 8'h80), QTRS_FULL * QF, 2, "R3 R9 fast read slot5");
    issue(4'hA, 1'b0, 3'd2, 8'h00, ok_st(3'd2, 8'h00), QTRS_FULL * QS, 2, "R3 read slot2 addr0");
    issue(4'hA, 1'b1, 3'd3, 8'h20, 16'h2000, 0, 1, "R5 absent slot");
    issue(4'h5, 1'b1, 3'd0, 8'h20, 16'h2000, 0, 1, "R5 wrong device class");
    issue(4'hA, 1'b1, 3'd1, 8'hFF, 16'h2000, 0, 1, "R6 byte address refused");
    issue(4'hA, 1'b1, 3'd1, 8'h7E, ok_st(3'd1, 8'h7E), QTRS_FULL * QF, 2, "R3 R10 read after error");
    wait_done();

    // R7: second command in the middle of a read
    issue(4'hA, 1'b1, 3'd0, 8'h33, ok_st(3'd0, 8'h33), QTRS_FULL * QF, 2, "R7 first command wins");
    repeat (20) @(negedge clk);
    cmd = {4'hA, 1'b1, 3'd2, 8'h44, 8'h00, 8'h00};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    wait_done();
    repeat (400) @(negedge clk);
    chk(status == ok_st(3'd0, 8'h33), "R7 status kept", status, ok_st(3'd0, 8'h33));

    // R8: operation bit set
    held = status;
    cmd = {4'hA, 1'b0, 3'd1, 8'h05, 8'h00, 8'h01};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(status[12] == 1'b0, "R8 no busy", status[12], 0);
    repeat (50) @(negedge clk);
    chk(status == held, "R8 status unchanged", status, held);
    chk(!scl_oe && !sda_oe, "R8 bus untouched", {scl_oe, sda_oe}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R4 run did not finish actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule